// File: doc/BRIEF.md
# Channel Status Ping-Pong Buffer

This block sits behind the frame decoder of a digital audio receiver. Each status block has 24 bytes. The decoder assembles these bytes and hands them over one byte-ready strobe at a time, with one byte for channel A and one for channel B. The block stores them in an eight-byte window that is overwritten cyclically, so each window slot is rewritten three times per block. A host reads the window through a plain combinational read port.

Two phase flags tell the host where the writer is:

- The half flag shows which four-byte half of the window is currently being filled. The host reads the other half.
- The pair flag shows which byte pair inside that half is stable enough to read.

In single-buffer mode only channel A is kept. In dual-buffer mode a second eight-byte window for channel B is filled in the same cycles, and both windows share one pair of flags.

Top module: `cs_pingpong`

## Requirements
- R1: After reset both flags read 0 and every read address returns 0. Byte strobes are ignored until the first block-start marker arrives.
- R2: Status byte n of a block (n from 0 to 23) is stored as the channel A byte at address 0x08 + (n mod 8). The read port returns that byte at that address.
- R3: When the written byte index n is odd, the pair flag becomes the inverse of bit 1 of n. This makes the flag high after byte 1, low after byte 3, and so on, toggling every second byte. An even index leaves the pair flag unchanged.
- R4: The half flag goes low after a byte with n mod 8 = 3 is written and high after a byte with n mod 8 = 7. No other byte changes it.
- R5: Stored data and both flags change on the first clock edge at which the strobe is sampled. Before that edge the old values remain visible.
- R6: A block-start marker that comes with a strobe makes that byte byte 0. A marker without a strobe makes the next strobed byte byte 0. This holds even when the marker arrives in the middle of a block.
- R7: After byte 23 the index wraps to 0. Further strobes without a block-start marker store nothing and change neither flag.
- R8: In dual-buffer mode (mode input 1), the channel B byte of index n is stored at 0x10 + (n mod 8) in the same cycle as the channel A byte. It follows the same flag sequencing.
- R9: In single-buffer mode (mode input 0), reads of 0x10–0x17 return 0 and channel B bytes are not stored.
- R10: Read addresses outside 0x08–0x17 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Byte-ready strobe for both channels |
| byte_a | input | 8 | Assembled status byte, channel A |
| byte_b | input | 8 | Assembled status byte, channel B |
| blk_start | input | 1 | Block-start marker |
| dual_mode | input | 1 | 1 = two channel buffers, 0 = channel A only |
| rd_addr | input | 5 | Host read address |
| rd_data | output | 8 | Host read data |
| pair_flag | output | 1 | Byte-pair phase flag |
| half_flag | output | 1 | Window-half phase flag |

## Verification
The hardest situation to reach from the ports is a restart in the middle of a block. In that case the pair and half flags still hold state from the interrupted block, and the new byte 0 must overwrite slot 0 without disturbing them. The stimulus reaches this by first running a partial block of ten bytes, then issuing a marker together with a strobe, and then running the block to its end. The stimulus also issues a marker alone, which checks that the next byte counts as byte 0. After every strobe the bench sweeps all 32 read addresses and compares them against a model computed from the index arithmetic.

// File: rtl/cs_pp_pkg.sv
`timescale 1ns/1ps
// Package: shared sizing and address map for the channel status ping-pong buffer.
// Assumes the window size is a power of two and that banks are laid out back to back.
package cs_pp_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int WIN    = 8;
    localparam int BLK    = 24;
    localparam int NCH    = 2;

    // Base address of the window that belongs to a channel.
    function automatic logic [ADDR_W-1:0] bank_base(input int ch);
        return ADDR_W'(WIN + ch * WIN);
    endfunction
endpackage

// File: rtl/cs_pp_seq.sv
`timescale 1ns/1ps
// Module: cs_pp_seq
// Tracks the byte index within a status block, decides whether a strobe is taken,
// and drives the pair and half phase flags.
// Assumes WIN is a power of two and at least 4, and BLK is a multiple of WIN.
module cs_pp_seq #(
    parameter int WIN = 8,
    parameter int BLK = 24,
    localparam int SLOT_W = $clog2(WIN),
    localparam int CNT_W  = $clog2(BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              blk_start,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              pair_flag,
    output logic              half_flag
);
    localparam int HALF = WIN / 2;

    logic [CNT_W-1:0] idx_q;
    logic             armed_q;
    logic [CNT_W-1:0] cur;
    logic             take;
    logic             last;

    // Index of the byte on the inputs, and whether it gets stored.
    always_comb begin
        cur     = blk_start ? '0 : idx_q;
        take    = byte_vld && (blk_start || armed_q);
        last    = (cur == CNT_W'(BLK - 1));
        wr_en   = take;
        wr_slot = cur[SLOT_W-1:0];
    end

    // Byte counter and armed state: wraps after the last byte and waits for a marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            armed_q <= 1'b0;
        end else if (take) begin
            idx_q   <= last ? '0 : cur + CNT_W'(1);
            armed_q <= !last;
        end else if (blk_start) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
        end
    end

    // Phase flags, updated from the index of each byte that is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_flag <= 1'b0;
            half_flag <= 1'b0;
        end else if (take) begin
            if (cur[0])
                pair_flag <= !cur[1];
            if (wr_slot == SLOT_W'(HALF - 1))
                half_flag <= 1'b0;
            else if (wr_slot == SLOT_W'(WIN - 1))
                half_flag <= 1'b1;
        end
    end

    // R3
    pair_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur[0]) |=> (pair_flag == !$past(cur[1])));

    // R4
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(half_flag));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !blk_start) |=> (idx_q == $past(idx_q)));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && !byte_vld) |=> (idx_q == '0 && armed_q));
endmodule

// File: rtl/cs_pp_bank.sv
`timescale 1ns/1ps
// Module: cs_pp_bank
// One window of WIN byte registers, written by slot and read through a combinational
// port that answers only for addresses inside its own range and only when enabled.
// Assumes BASE is aligned to WIN.
module cs_pp_bank #(
    parameter int BYTE_W = 8,
    parameter int WIN    = 8,
    parameter int ADDR_W = 5,
    parameter logic [ADDR_W-1:0] BASE = 5'h08,
    localparam int SLOT_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [WIN];
    logic              hit;

    // Byte storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wslot] <= wdata;
        end
    end

    // Range decode and read of one byte.
    always_comb begin
        hit     = rd_en && (rd_addr[ADDR_W-1:SLOT_W] == BASE[ADDR_W-1:SLOT_W]);
        rd_data = hit ? mem[rd_addr[SLOT_W-1:0]] : '0;
    end

    // R2
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(wslot)] == $past(wdata)));
endmodule

// File: rtl/cs_pingpong.sv
`timescale 1ns/1ps
// Module: cs_pingpong
// Top of the channel status ping-pong buffer. One sequencer drives one bank per channel.
// Bank B is written and readable only in dual mode. The read data is the OR of the
// bank outputs, because at most one bank answers for any address.
module cs_pingpong #(
    parameter int BYTE_W = cs_pp_pkg::BYTE_W,
    parameter int ADDR_W = cs_pp_pkg::ADDR_W,
    parameter int WIN    = cs_pp_pkg::WIN,
    parameter int BLK    = cs_pp_pkg::BLK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    input  logic              blk_start,
    input  logic              dual_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pair_flag,
    output logic              half_flag
);
    localparam int NCH    = cs_pp_pkg::NCH;
    localparam int SLOT_W = $clog2(WIN);

    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [BYTE_W-1:0] wdata  [NCH];
    logic [BYTE_W-1:0] part   [NCH];

    assign wdata[0] = byte_a;
    assign wdata[1] = byte_b;

    cs_pp_seq #(.WIN(WIN), .BLK(BLK)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .blk_start(blk_start),
        .wr_en(wr_en), .wr_slot(wr_slot), .pair_flag(pair_flag), .half_flag(half_flag)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
        logic ch_on;
        assign ch_on = (ch == 0) || dual_mode;
        cs_pp_bank #(
            .BYTE_W(BYTE_W), .WIN(WIN), .ADDR_W(ADDR_W),
            .BASE(cs_pp_pkg::bank_base(ch))
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .we(wr_en && ch_on), .wslot(wr_slot),
            .wdata(wdata[ch]), .rd_addr(rd_addr), .rd_en(ch_on), .rd_data(part[ch])
        );
    end

    // Merge the bank outputs into the read port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) rd_data = rd_data | part[i];
    end

    // R9
    single_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && rd_addr >= ADDR_W'(2*WIN) && rd_addr < ADDR_W'(3*WIN)) |-> (rd_data == '0));
endmodule

// File: tb/sim_cs_pingpong.sv
`timescale 1ns/100ps
module sim_cs_pingpong;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       byte_vld = 0;
    logic [7:0] byte_a = 0, byte_b = 0;
    logic       blk_start = 0;
    logic       dual_mode = 0;
    logic [4:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       pair_flag, half_flag;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] exp_a [8];
    logic [7:0] exp_b [8];
    logic       e_pair, e_half, e_arm;
    int         e_idx;

    always #4 clk = ~clk;

    cs_pingpong u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_a(byte_a), .byte_b(byte_b),
        .blk_start(blk_start), .dual_mode(dual_mode), .rd_addr(rd_addr),
        .rd_data(rd_data), .pair_flag(pair_flag), .half_flag(half_flag)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, expv, rd_addr);
        end
    endtask

    // Model of one cycle, computed from the requirement arithmetic.
    task automatic model(input bit vld, input bit st, input logic [7:0] a, input logic [7:0] b);
        int cur;
        bit take;
        take = vld && (st || e_arm);
        cur  = st ? 0 : e_idx;
        if (take) begin
            exp_a[cur % 8] = a;
            if (dual_mode) exp_b[cur % 8] = b;
            if (cur % 2 == 1) e_pair = ((cur / 2) % 2) == 0;
            if (cur % 8 == 3) e_half = 0;
            if (cur % 8 == 7) e_half = 1;
            e_idx = (cur == 23) ? 0 : cur + 1;
            e_arm = (cur != 23);
        end else if (st) begin
            e_idx = 0;
            e_arm = 1;
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        if (a >= 8 && a < 16) return exp_a[a - 8];
        if (a >= 16 && a < 24 && dual_mode) return exp_b[a - 16];
        return 8'h00;
    endfunction

    function automatic string tag_for(input int a, input string ph);
        if (a < 8 || a >= 24) return "R10";
        if (a >= 16 && !dual_mode) return "R9";
        return ph;
    endfunction

    task automatic check_all(input string ph);
        chk({7'd0, pair_flag}, {7'd0, e_pair}, "R3");
        chk({7'd0, half_flag}, {7'd0, e_half}, "R4");
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            #0.1;
            chk(rd_data, exp_rd(a), tag_for(a, ph));
        end
    endtask

    // Drive one cycle at the falling edge, let the rising edge take it, then check.
    task automatic step(input bit vld, input bit st, input logic [7:0] a, input logic [7:0] b, input string ph);
        @(negedge clk);
        byte_vld = vld; blk_start = st; byte_a = a; byte_b = b;
        @(posedge clk);
        model(vld, st, a, b);
        @(negedge clk);
        byte_vld = 0; blk_start = 0;
        check_all(ph);
    endtask

    task automatic run_block(input int first, input int last_n, input int seed, input string ph);
        for (int n = first; n <= last_n; n++)
            step(1, n == first && first == 0, 8'(n * 37 + seed), 8'(~(n * 11 + seed)), ph);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin exp_a[i] = 0; exp_b[i] = 0; end
        e_pair = 0; e_half = 0; e_arm = 0; e_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        check_all("R1");
        // R1: strobes before any marker are ignored
        step(1, 0, 8'hA5, 8'h5A, "R1");
        step(1, 0, 8'h3C, 8'hC3, "R1");
        // R2 R3 R4: full block, single mode
        run_block(0, 23, 3, "R2");
        // R7: strobes after byte 23 without a marker
        step(1, 0, 8'hEE, 8'h11, "R7");
        step(1, 0, 8'hDD, 8'h22, "R7");
        // R5: the write shows only after the edge
        @(negedge clk);
        rd_addr = 5'h08;
        byte_vld = 1; blk_start = 1; byte_a = 8'h5A; byte_b = 8'h00;
        #1 chk(rd_data, exp_a[0], "R5");
        @(posedge clk);
        model(1, 1, 8'h5A, 8'h00);
        #1 chk(rd_data, 8'h5A, "R5");
        @(negedge clk);
        byte_vld = 0; blk_start = 0;
        check_all("R5");
        // R6: marker alone, then a partial block, then a marker with a byte mid-block
        step(0, 1, 8'h00, 8'h00, "R6");
        for (int n = 0; n < 10; n++) step(1, 0, 8'(n * 13 + 90), 8'(n), "R6");
        step(1, 1, 8'h77, 8'h88, "R6");
        run_block(1, 23, 41, "R6");
        // R8: dual mode block
        dual_mode = 1;
        run_block(0, 23, 200, "R8");
        step(1, 0, 8'h99, 8'h66, "R7");
        // R9: single mode hides and freezes bank B
        dual_mode = 0;
        #0.1 check_all("R9");
        run_block(0, 23, 17, "R9");
        dual_mode = 1;
        #0.1 check_all("R9");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule